// File: doc/BRIEF.md
# Host-to-controller command mailbox

This block is the register window through which a host processor hands work to an embedded power-management controller and picks up the answer. The host sees a small 32-bit register space with a command word, a status word, two pointer registers, a four-word input buffer and a four-word result buffer. Writing the command word while the mailbox is idle latches the command and rings a one-cycle doorbell towards the controller. The controller sees the command code, sub-command, byte length, both pointers and the input words that the length covers.

When the controller has served the request it pulses a completion strobe carrying an error flag, an 8-bit error code and up to four result words. The mailbox then drops its busy flag, records the outcome in the status word and captures the results for the host to read as words or single bytes. If the host asked for it in the command word, a pending flag is raised that also drives the host interrupt line. The host clears the flag by writing the status word with the pending bit set.

Top module: `host_ctrl_mailbox`

## Requirements
- R1: After reset the status word reads 0, and host_irq and ctl_doorbell are 0.
- R2: A host write to offset 0x00 while idle sets busy (status bit 0) and pulses ctl_doorbell for exactly one cycle, both visible after the next clock edge. The latched word drives ctl_cmd from bits 7:0, ctl_sub from bits 15:12 and ctl_len from bits 23:16.
- R3: A write to offset 0x00 while busy is ignored: no doorbell, the latched command word (read back at 0x00) is unchanged, and the status is unchanged.
- R4: ctl_done while busy clears busy at the next edge and stores ctl_err in status bit 1, ctl_code in status bits 23:16 and ctl_result word k at offset 0x90+4k. ctl_done while idle changes nothing.
- R5: The pending flag (status bit 2) drives host_irq. Completion sets it only when bit 8 of the latched command word is 1.
- R6: A status write (offset 0x04) with bit 2 set clears pending, and one with bit 2 clear leaves it alone. If completion with bit 8 set happens in the same cycle as the clearing write, pending ends up set.
- R7: Input buffer word k (written at 0x80+4k) appears on ctl_inbuf bits 32k+31:32k only when k < ceil(L/4). L is the latched length, and any length above 16 is taken as 16. All other words of ctl_inbuf read as 0.
- R8: The source pointer (0x08) and destination pointer (0x0C) read back what was written and drive ctl_src and ctl_dst. Input buffer words read back at their offsets.
- R9: While busy, writes to the pointer registers and the input buffer are ignored.
- R10: With host_rd_byte=1 a read returns byte host_addr[1:0] of the addressed word in bits 7:0 (byte 0 = bits 7:0), with bits 31:8 zero.
- R11: Reads of unmapped offsets return 0. Writes to unmapped offsets or to the result buffer have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Host byte address |
| host_wr | input | 1 | Host write enable |
| host_wdata | input | 32 | Host write data |
| host_rd_byte | input | 1 | Byte read select for host_rdata |
| host_rdata | output | 32 | Host read data (combinational from host_addr) |
| host_irq | output | 1 | Completion interrupt (pending flag) |
| ctl_doorbell | output | 1 | One-cycle new-command pulse to the controller |
| ctl_cmd | output | 8 | Latched command code |
| ctl_sub | output | 4 | Latched sub-command |
| ctl_len | output | 8 | Latched input length in bytes |
| ctl_src | output | 32 | Source pointer register |
| ctl_dst | output | 32 | Destination pointer register |
| ctl_inbuf | output | 128 | Input words covered by the length, others zero |
| ctl_done | input | 1 | Controller completion strobe |
| ctl_err | input | 1 | Error flag sent with completion |
| ctl_code | input | 8 | Error code sent with completion |
| ctl_result | input | 128 | Result words sent with completion |

## Verification
Two functions can fall on the same edge: the controller's completion setting the pending flag, and the host's status write clearing it. The bench drives both in one cycle on a command that has bit 8 set, and expects pending and host_irq to stay high afterwards. It also drives them in the other combinations. Random stimulus then keeps producing ctl_done pulses together with status writes, command writes and buffer writes, and a bench model predicts status, host_irq and the read data after every cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Register selection produced by the address decoder
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_STAT,
        SEL_SRC,
        SEL_DST,
        SEL_IN,
        SEL_OUT
    } mbox_sel_e;

    // Register offsets (host byte addresses)
    localparam int OFF_CMD  = 'h00;
    localparam int OFF_STAT = 'h04;
    localparam int OFF_SRC  = 'h08;
    localparam int OFF_DST  = 'h0C;
    localparam int OFF_IN   = 'h80;
    localparam int OFF_OUT  = 'h90;

    // Command word field positions
    localparam int CMD_LSB = 0;
    localparam int IRQ_BIT = 8;
    localparam int SUB_LSB = 12;
    localparam int LEN_LSB = 16;

    // Status word field positions
    localparam int ST_BUSY     = 0;
    localparam int ST_ERR      = 1;
    localparam int ST_PEND     = 2;
    localparam int ST_CODE_LSB = 16;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DW        = 32,
    parameter int BUF_WORDS = 4,
    parameter int IDX_W     = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output mbox_sel_e         sel,
    output logic [IDX_W-1:0]  idx
);
    localparam int BYTES_PER_WORD = DW / 8;
    localparam int SPAN           = BUF_WORDS * BYTES_PER_WORD;
    localparam int WSH            = $clog2(BYTES_PER_WORD);

    logic [ADDR_W-WSH-1:0] waddr;
    int                    a_int;

    always_comb begin
        waddr = addr[ADDR_W-1:WSH];
        a_int = int'(addr);
        sel   = SEL_NONE;
        idx   = '0;
        if (waddr == (ADDR_W-WSH)'(OFF_CMD >> WSH)) begin
            sel = SEL_CMD;
        end else if (waddr == (ADDR_W-WSH)'(OFF_STAT >> WSH)) begin
            sel = SEL_STAT;
        end else if (waddr == (ADDR_W-WSH)'(OFF_SRC >> WSH)) begin
            sel = SEL_SRC;
        end else if (waddr == (ADDR_W-WSH)'(OFF_DST >> WSH)) begin
            sel = SEL_DST;
        end else if (a_int >= OFF_IN && a_int < OFF_IN + SPAN) begin
            sel = SEL_IN;
            idx = IDX_W'((a_int - OFF_IN) >> WSH);
        end else if (a_int >= OFF_OUT && a_int < OFF_OUT + SPAN) begin
            sel = SEL_OUT;
            idx = IDX_W'((a_int - OFF_OUT) >> WSH);
        end
    end

endmodule

// File: rtl/mbox_ctrl_core.sv
module mbox_ctrl_core
    import mbox_pkg::*;
#(
    parameter int DW     = 32,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              stat_wr,
    input  logic [DW-1:0]     wdata,
    input  logic              done,
    input  logic              done_err,
    input  logic [CODE_W-1:0] done_code,
    output logic              busy,
    output logic              err,
    output logic [CODE_W-1:0] code,
    output logic              pend,
    output logic              doorbell,
    output logic [DW-1:0]     cmd_word,
    output logic              finish
);
    typedef struct packed {
        logic              busy;
        logic              err;
        logic [CODE_W-1:0] code;
        logic              pend;
        logic              db;
        logic [DW-1:0]     cmd;
    } core_t;

    core_t st_q, st_d;
    logic  take_d, fin_d, ack_d;

    always_comb begin
        st_d   = st_q;
        take_d = cmd_wr && !st_q.busy;
        fin_d  = done && st_q.busy;
        ack_d  = stat_wr && wdata[ST_PEND];
        st_d.db = take_d;
        if (take_d) begin
            st_d.busy = 1'b1;
            st_d.cmd  = wdata;
        end else if (fin_d) begin
            st_d.busy = 1'b0;
            st_d.err  = done_err;
            st_d.code = done_code;
        end
        // a completion that requests an interrupt outranks a same-cycle clear
        st_d.pend = (st_q.pend && !ack_d) || (fin_d && st_q.cmd[IRQ_BIT]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign err      = st_q.err;
    assign code     = st_q.code;
    assign pend     = st_q.pend;
    assign doorbell = st_q.db;
    assign cmd_word = st_q.cmd;
    assign finish   = fin_d;

    assert_doorbell_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !st_q.busy) |=> (st_q.busy && st_q.db));

    assert_doorbell_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.db |=> !st_q.db);

    assert_busy_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && st_q.busy) |=> ($stable(st_q.cmd) && !st_q.db));

    assert_done_clears_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.busy) |=> !st_q.busy);

    assert_irq_needs_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(st_q.cmd[IRQ_BIT] && st_q.busy));

    assert_ack_clears_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wdata[ST_PEND] && !(done && st_q.busy)) |=> !st_q.pend);

endmodule

// File: rtl/mbox_buffers.sv
module mbox_buffers
    import mbox_pkg::*;
#(
    parameter int DW        = 32,
    parameter int BUF_WORDS = 4,
    parameter int LEN_W     = 8,
    parameter int IDX_W     = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  mbox_sel_e               sel,
    input  logic [IDX_W-1:0]        idx,
    input  logic [DW-1:0]           wdata,
    input  logic                    busy,
    input  logic                    finish,
    input  logic [BUF_WORDS*DW-1:0] result,
    input  logic [LEN_W-1:0]        len,
    output logic [DW-1:0]           src,
    output logic [DW-1:0]           dst,
    output logic [DW-1:0]           in_rd,
    output logic [DW-1:0]           out_rd,
    output logic [BUF_WORDS*DW-1:0] in_view
);
    localparam int BYTES_PER_WORD = DW / 8;
    localparam int MAX_BYTES      = BUF_WORDS * BYTES_PER_WORD;
    localparam int WSH            = $clog2(BYTES_PER_WORD);

    typedef struct packed {
        logic [BUF_WORDS-1:0][DW-1:0] inw;
        logic [BUF_WORDS-1:0][DW-1:0] outw;
        logic [DW-1:0]                src;
        logic [DW-1:0]                dst;
    } bufs_t;

    bufs_t buf_q, buf_d;
    logic [LEN_W-1:0] len_cl_d;
    logic [LEN_W-1:0] used_d;

    always_comb begin
        buf_d = buf_q;
        if (wr && !busy) begin
            case (sel)
                SEL_SRC: buf_d.src      = wdata;
                SEL_DST: buf_d.dst      = wdata;
                SEL_IN:  buf_d.inw[idx] = wdata;
                default: ;
            endcase
        end
        if (finish) begin
            buf_d.outw = result;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    // number of words covered by the latched byte length
    always_comb begin
        len_cl_d = (len > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : len;
        used_d   = (len_cl_d + LEN_W'(BYTES_PER_WORD - 1)) >> WSH;
    end

    for (genvar k = 0; k < BUF_WORDS; k++) begin : g_view
        assign in_view[k*DW +: DW] = (LEN_W'(k) < used_d) ? buf_q.inw[k] : '0;
    end

    assign src    = buf_q.src;
    assign dst    = buf_q.dst;
    assign in_rd  = buf_q.inw[idx];
    assign out_rd = buf_q.outw[idx];

    assert_frozen_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(buf_q.inw) && $stable(buf_q.src) && $stable(buf_q.dst)));

    assert_results_only_on_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(buf_q.outw));

endmodule

// File: rtl/host_ctrl_mailbox.sv
module host_ctrl_mailbox
    import mbox_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DW        = 32,
    parameter int BUF_WORDS = 4,
    parameter int CMD_W     = 8,
    parameter int SUB_W     = 4,
    parameter int LEN_W     = 8,
    parameter int CODE_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic                    host_wr,
    input  logic [DW-1:0]           host_wdata,
    input  logic                    host_rd_byte,
    output logic [DW-1:0]           host_rdata,
    output logic                    host_irq,
    output logic                    ctl_doorbell,
    output logic [CMD_W-1:0]        ctl_cmd,
    output logic [SUB_W-1:0]        ctl_sub,
    output logic [LEN_W-1:0]        ctl_len,
    output logic [DW-1:0]           ctl_src,
    output logic [DW-1:0]           ctl_dst,
    output logic [BUF_WORDS*DW-1:0] ctl_inbuf,
    input  logic                    ctl_done,
    input  logic                    ctl_err,
    input  logic [CODE_W-1:0]       ctl_code,
    input  logic [BUF_WORDS*DW-1:0] ctl_result
);
    localparam int IDX_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

    mbox_sel_e         sel;
    logic [IDX_W-1:0]  idx;
    logic              busy, err, pend, finish;
    logic [CODE_W-1:0] code;
    logic [DW-1:0]     cmd_word, in_rd, out_rd;
    logic [DW-1:0]     word_d, shifted_d;

    mbox_decode #(
        .ADDR_W(ADDR_W), .DW(DW), .BUF_WORDS(BUF_WORDS), .IDX_W(IDX_W)
    ) u_decode (
        .addr(host_addr), .sel(sel), .idx(idx)
    );

    mbox_ctrl_core #(
        .DW(DW), .CODE_W(CODE_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(host_wr && sel == SEL_CMD),
        .stat_wr(host_wr && sel == SEL_STAT),
        .wdata(host_wdata),
        .done(ctl_done), .done_err(ctl_err), .done_code(ctl_code),
        .busy(busy), .err(err), .code(code), .pend(pend),
        .doorbell(ctl_doorbell), .cmd_word(cmd_word), .finish(finish)
    );

    mbox_buffers #(
        .DW(DW), .BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) u_bufs (
        .clk(clk), .rst_n(rst_n),
        .wr(host_wr), .sel(sel), .idx(idx), .wdata(host_wdata),
        .busy(busy), .finish(finish), .result(ctl_result),
        .len(ctl_len),
        .src(ctl_src), .dst(ctl_dst),
        .in_rd(in_rd), .out_rd(out_rd), .in_view(ctl_inbuf)
    );

    assign ctl_cmd  = cmd_word[CMD_LSB +: CMD_W];
    assign ctl_sub  = cmd_word[SUB_LSB +: SUB_W];
    assign ctl_len  = cmd_word[LEN_LSB +: LEN_W];
    assign host_irq = pend;

    always_comb begin
        word_d = '0;
        case (sel)
            SEL_CMD:  word_d = cmd_word;
            SEL_STAT: begin
                word_d[ST_BUSY]              = busy;
                word_d[ST_ERR]               = err;
                word_d[ST_PEND]              = pend;
                word_d[ST_CODE_LSB +: CODE_W] = code;
            end
            SEL_SRC:  word_d = ctl_src;
            SEL_DST:  word_d = ctl_dst;
            SEL_IN:   word_d = in_rd;
            SEL_OUT:  word_d = out_rd;
            default:  word_d = '0;
        endcase
        shifted_d  = word_d >> {host_addr[1:0], 3'b000};
        host_rdata = host_rd_byte ? {{(DW-8){1'b0}}, shifted_d[7:0]} : word_d;
    end

endmodule

// File: tb/host_ctrl_mailbox_bench.sv
module host_ctrl_mailbox_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   host_addr = '0;
    logic         host_wr = 1'b0;
    logic [31:0]  host_wdata = '0;
    logic         host_rd_byte = 1'b0;
    logic [31:0]  host_rdata;
    logic         host_irq;
    logic         ctl_doorbell;
    logic [7:0]   ctl_cmd;
    logic [3:0]   ctl_sub;
    logic [7:0]   ctl_len;
    logic [31:0]  ctl_src, ctl_dst;
    logic [127:0] ctl_inbuf;
    logic         ctl_done = 1'b0;
    logic         ctl_err = 1'b0;
    logic [7:0]   ctl_code = '0;
    logic [127:0] ctl_result = '0;

    host_ctrl_mailbox u_host_ctrl_mailbox (.*);

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model of the mailbox
    logic        m_busy = 0, m_err = 0, m_pend = 0, m_db = 0;
    logic [7:0]  m_code = 0;
    logic [31:0] m_cmd = 0, m_src = 0, m_dst = 0;
    logic [31:0] m_in [4];
    logic [31:0] m_out [4];

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        return {8'h00, m_code, 13'h0, m_pend, m_err, m_busy};
    endfunction

    function automatic logic [127:0] m_view();
        logic [127:0] v = '0;
        int l = (m_cmd[23:16] > 8'd16) ? 16 : int'(m_cmd[23:16]);
        int used = (l + 3) / 4;
        for (int k = 0; k < 4; k++)
            if (k < used) v[k*32 +: 32] = m_in[k];
        return v;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a, input logic bm);
        logic [31:0] w;
        case (a[7:2]) inside
            6'h00: w = m_cmd;
            6'h01: w = m_status();
            6'h02: w = m_src;
            6'h03: w = m_dst;
            [6'h20:6'h23]: w = m_in[a[3:2]];
            [6'h24:6'h27]: w = m_out[a[3:2]];
            default: w = '0;
        endcase
        if (bm) w = {24'h0, 8'(w >> (8 * a[1:0]))};
        return w;
    endfunction

    task automatic rd_check(input logic [7:0] a, input logic bm, input string tag);
        host_addr = a;
        host_rd_byte = bm;
        #1;
        chk(tag, host_rdata, m_read(a, bm));
    endtask

    // one clock cycle of stimulus; model update; output checks after the edge
    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                        input logic dn, input logic de, input logic [7:0] dc,
                        input logic [127:0] res);
        logic take, fin, ack, pre_busy, npend;
        host_wr = wr; host_addr = a; host_wdata = wd;
        ctl_done = dn; ctl_err = de; ctl_code = dc; ctl_result = res;
        pre_busy = m_busy;
        take  = wr && a[7:2] == 6'h00 && !m_busy;
        fin   = dn && m_busy;
        ack   = wr && a[7:2] == 6'h01 && wd[2];
        npend = (m_pend && !ack) || (fin && m_cmd[8]);
        if (take) begin
            m_busy = 1; m_cmd = wd;
        end else if (fin) begin
            m_busy = 0; m_err = de; m_code = dc;
            for (int k = 0; k < 4; k++) m_out[k] = res[k*32 +: 32];
        end
        if (wr && !pre_busy) begin
            case (a[7:2]) inside
                6'h02: m_src = wd;
                6'h03: m_dst = wd;
                [6'h20:6'h23]: m_in[a[3:2]] = wd;
                default: ;
            endcase
        end
        m_pend = npend;
        m_db = take;
        @(negedge clk);
        host_wr = 0; ctl_done = 0;
        chk("R2 doorbell", ctl_doorbell, m_db);
        chk("R5 host_irq", host_irq, m_pend);
        chk("R2 ctl_cmd", ctl_cmd, m_cmd[7:0]);
        chk("R2 ctl_sub", ctl_sub, m_cmd[15:12]);
        chk("R2 ctl_len", ctl_len, m_cmd[23:16]);
        chk("R7 ctl_inbuf", ctl_inbuf, m_view());
        chk("R8 ctl_src", ctl_src, m_src);
        chk("R8 ctl_dst", ctl_dst, m_dst);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        step(1, a, d, 0, 0, 0, '0);
    endtask

    task automatic idle();
        step(0, 8'h40, 0, 0, 0, 0, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all R): got hang expected end of run");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [127:0] res;
        void'($urandom(32'd2718));
        for (int k = 0; k < 4; k++) begin m_in[k] = 0; m_out[k] = 0; end
        repeat (3) @(negedge clk);
        rd_check(8'h04, 0, "R1 status after reset");
        chk("R1 host_irq", host_irq, 0);
        chk("R1 doorbell", ctl_doorbell, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: pointers and input buffer
        wr_reg(8'h08, 32'h1000_0040);
        wr_reg(8'h0C, 32'h2000_0080);
        for (int k = 0; k < 4; k++) wr_reg(8'(8'h80 + 4 * k), 32'h1111_1111 * (k + 1));
        rd_check(8'h08, 0, "R8 src readback");
        rd_check(8'h0C, 0, "R8 dst readback");
        rd_check(8'h84, 0, "R8 inbuf readback");

        // R2/R7: command 0x3A, sub 7, irq request, length 5 -> two words
        wr_reg(8'h00, 32'h0005_713A);
        rd_check(8'h04, 0, "R2 busy set");
        chk("R7 length 5 view", ctl_inbuf, {64'h0, 32'h2222_2222, 32'h1111_1111});
        idle();

        // R3/R9: writes while busy
        wr_reg(8'h00, 32'h0010_00FF);
        wr_reg(8'h08, 32'hDEAD_BEEF);
        wr_reg(8'h80, 32'hDEAD_BEEF);
        rd_check(8'h00, 0, "R3 command kept");
        rd_check(8'h04, 0, "R3 status kept");
        rd_check(8'h08, 0, "R9 src kept");
        rd_check(8'h80, 0, "R9 inbuf kept");

        // R4/R5: completion with error 6
        res = {32'hA0A1_A2A3, 32'hB0B1_B2B3, 32'hC0C1_C2C3, 32'hD0D1_D2D3};
        step(0, 8'h40, 0, 1, 1, 8'd6, res);
        rd_check(8'h04, 0, "R4 status after completion");
        chk("R5 irq raised", host_irq, 1);
        rd_check(8'h94, 0, "R4 result word 1");
        rd_check(8'h96, 1, "R10 byte read");
        rd_check(8'h9F, 1, "R10 top byte read");

        // R6: clear with bit 2 low, then high
        wr_reg(8'h04, 32'h0000_0003);
        chk("R6 no-op status write", host_irq, 1);
        wr_reg(8'h04, 32'h0000_0004);
        chk("R6 ack clears", host_irq, 0);

        // R5: command without irq request
        wr_reg(8'h00, 32'h0000_0011);
        chk("R7 length 0 view", ctl_inbuf, 128'h0);
        step(0, 8'h40, 0, 1, 0, 8'd0, ~res);
        chk("R5 no irq without request", host_irq, 0);

        // R4: completion while idle ignored
        step(0, 8'h40, 0, 1, 1, 8'd3, res);
        rd_check(8'h04, 0, "R4 idle completion ignored");
        rd_check(8'h90, 0, "R4 idle results ignored");

        // R7 clamp, R6 same-cycle completion and clear
        wr_reg(8'h00, 32'h0028_01EE);
        chk("R7 length clamp", ctl_inbuf, m_view());
        step(1, 8'h04, 32'h4, 1, 0, 8'd2, res);
        chk("R6 completion beats clear", host_irq, 1);
        rd_check(8'h04, 0, "R6 status after collision");
        wr_reg(8'h04, 32'h4);

        // R11: unmapped and read-only
        rd_check(8'hA4, 0, "R11 unmapped read");
        wr_reg(8'h90, 32'h5555_5555);
        wr_reg(8'hC0, 32'h5555_5555);
        rd_check(8'h90, 0, "R11 result buffer read-only");

        // constrained random mix
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] a = 8'h40;
            logic [31:0] wd = $urandom;
            logic w = 1;
            int op = $urandom_range(0, 9);
            case (op)
                0, 1: begin a = 8'h00; wd[23:16] = 8'($urandom_range(0, 20)); end
                2: a = 8'h04;
                3: a = 8'h08;
                4: a = 8'h0C;
                5, 6: a = 8'(8'h80 + 4 * $urandom_range(0, 3));
                7: a = ($urandom_range(0, 1) != 0) ? 8'h94 : 8'hE0;
                default: w = 0;
            endcase
            res = {$urandom, $urandom, $urandom, $urandom};
            step(w, a, wd, $urandom_range(0, 3) == 0, 1'($urandom), 8'($urandom_range(0, 7)), res);
            rd_check(($urandom_range(0, 1) != 0) ? 8'({3'b100, 5'($urandom)}) : 8'($urandom),
                     1'($urandom), "R10 R11 random read");
            rd_check(8'h04, 0, "R4 R6 random status");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule